// File: doc/BRIEF.md
# Double-Speed CPU to Multiplexed Bus Cycle Translator

This block lets a processor core clocked at exactly twice the system bus rate run transfers on a slower synchronous bus whose address and data share one set of wires. The two clocks are phase-locked. The block therefore runs entirely on the fast clock and keeps a phase bit that marks which fast edges coincide with a bus-clock rising edge. It drives the bus clock from that bit. All system-side strobes change only on those shared edges, so the board sees cycles that look as if a native bus-speed processor produced them.

A fast-side transfer request is turned into a system cycle as follows. The start strobe is held for one full bus period while the address is on the shared bus. The address is also latched into a holding register that stays stable until the transfer ends. The data phase follows, and each acknowledge from the system is turned into a one-fast-cycle acknowledge to the core. Read data is handed over with that acknowledge. After the last beat, the bus-busy output is released for at least one full bus period before the next transfer can claim it, which keeps the board arbiter from stalling.

Top module: `x2_bus_translator`

## Requirements
- R1: During and right after reset, `sys_ts_n`, `sys_bb_n` and `cpu_ta_n` are high and `sys_ad_oe` is low.
- R2: `bus_clk` toggles on every fast clock edge and is low just before each bus edge. A bus edge is a fast edge at which `bus_clk` was 0. `sys_ts_n`, `sys_bb_n` and `sys_ad_oe` change only on bus edges.
- R3: A core request (`cpu_ts_n` low for one fast cycle) starts a system cycle at the first bus edge at or after it. `sys_ts_n` then shows low 1 fast cycle later when the request was sampled on a bus edge, and 2 fast cycles later otherwise. `sys_ts_n` stays low for exactly one bus period, with `sys_ad_oe` = 1 and the address on `sys_ad_out`. The address, direction and burst flag are those present with the request, even if the core changes them afterwards.
- R4: `sys_addr_hold` takes the address at the start edge and stays unchanged until the transfer ends.
- R5: `sys_bb_n` is low from the start edge until the bus edge that samples the last acknowledge. It then stays high for at least one full bus period before it falls again.
- R6: Each `sys_ta_n` = 0 sampled on a bus edge in the data phase produces `cpu_ta_n` low for exactly one fast cycle, starting at that edge. For reads, `cpu_rdata` then holds the `sys_ad_in` value sampled at that edge.
- R7: With `cpu_burst` = 1, a transfer ends after the fourth acknowledge. With `cpu_burst` = 0, it ends after the first.
- R8: For writes (`cpu_rd` = 0), `sys_ad_oe` is 1 throughout the data phase. `sys_ad_out` carries `cpu_wdata` as captured at the latest fast edge, which is no later than the middle of each bus period.
- R9: `sys_ta_n` is ignored outside the data phase: during idle, the address period and the release gap.
- R10: Any number of bus periods with `sys_ta_n` high may pass before each acknowledge, and the transfer waits for them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast (core) clock, twice the bus rate |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_ts_n | input | 1 | Core transfer request, active low, one fast cycle |
| cpu_rd | input | 1 | Direction with the request: 1 read, 0 write |
| cpu_burst | input | 1 | 1 selects a four-beat burst |
| cpu_addr | input | W | Request address |
| cpu_wdata | input | W | Write data for the current beat |
| cpu_ta_n | output | 1 | Acknowledge pulse to the core, active low |
| cpu_rdata | output | W | Read data for the acknowledged beat |
| bus_clk | output | 1 | Bus clock derived from the phase bit |
| sys_ts_n | output | 1 | System transfer start, active low |
| sys_bb_n | output | 1 | System bus busy, active low |
| sys_ad_out | output | W | Value driven onto the shared address/data bus |
| sys_ad_oe | output | 1 | Drive enable for the shared bus |
| sys_ad_in | input | W | Value read from the shared bus |
| sys_ta_n | input | 1 | System acknowledge, active low |
| sys_addr_hold | output | W | Address held for the whole transfer |

## Verification
The system-side start shows 1 or 2 fast cycles after the core request, depending on `bus_clk` at the request. The bench works out which of the two applies from `bus_clk` when it drives the request, and then counts falling edges until it sees the start. The model of the system slave acts once per bus period, at the falling edge where `bus_clk` is low. At that point it checks the address, the held address, busy and write data. It drives `sys_ta_n` there, so the acknowledge is sampled at the next bus edge. The matching core acknowledge and read data are then checked at the very next falling edge, which has `bus_clk` high. Write data for a later beat is checked half a bus period after the preceding acknowledge, once the mid-period capture has taken place.

// File: rtl/x2_bus_translator.sv
module x2_bus_translator #(
  parameter int W         = 32,
  parameter int BURST_LEN = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cpu_ts_n,
  input  logic         cpu_rd,
  input  logic         cpu_burst,
  input  logic [W-1:0] cpu_addr,
  input  logic [W-1:0] cpu_wdata,
  output logic         cpu_ta_n,
  output logic [W-1:0] cpu_rdata,
  output logic         bus_clk,
  output logic         sys_ts_n,
  output logic         sys_bb_n,
  output logic [W-1:0] sys_ad_out,
  output logic         sys_ad_oe,
  input  logic [W-1:0] sys_ad_in,
  input  logic         sys_ta_n,
  output logic [W-1:0] sys_addr_hold
);
  localparam int BW = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

  typedef enum logic [1:0] {IDLE, ADDR, DATA, GAP} st_t;
  st_t st;

  logic          phase, pend, req_rd, req_burst, cur_rd, cur_burst;
  logic [W-1:0]  req_addr;
  logic [BW-1:0] beat;

  wire          bedge     = ~phase;
  wire          free      = (st == IDLE) || (st == GAP);
  wire          ts_now    = ~cpu_ts_n;
  wire          go        = free && bedge && (pend || ts_now);
  wire [W-1:0]  sel_addr  = ts_now ? cpu_addr  : req_addr;
  wire          sel_rd    = ts_now ? cpu_rd    : req_rd;
  wire          sel_burst = ts_now ? cpu_burst : req_burst;
  wire          ack       = (st == DATA) && bedge && ~sys_ta_n;
  wire          last      = ~cur_burst || (beat == BW'(BURST_LEN - 1));

  assign bus_clk = phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase         <= 1'b0;
      st            <= IDLE;
      pend          <= 1'b0;
      req_rd        <= 1'b0;
      req_burst     <= 1'b0;
      req_addr      <= '0;
      cur_rd        <= 1'b0;
      cur_burst     <= 1'b0;
      beat          <= '0;
      cpu_ta_n      <= 1'b1;
      cpu_rdata     <= '0;
      sys_ts_n      <= 1'b1;
      sys_bb_n      <= 1'b1;
      sys_ad_out    <= '0;
      sys_ad_oe     <= 1'b0;
      sys_addr_hold <= '0;
    end else begin
      phase    <= ~phase;
      cpu_ta_n <= ~ack;
      if (ack && cur_rd) cpu_rdata <= sys_ad_in;
      case (st)
        IDLE, GAP: begin
          if (go) begin
            st            <= ADDR;
            pend          <= 1'b0;
            cur_rd        <= sel_rd;
            cur_burst     <= sel_burst;
            beat          <= '0;
            sys_ts_n      <= 1'b0;
            sys_bb_n      <= 1'b0;
            sys_ad_out    <= sel_addr;
            sys_ad_oe     <= 1'b1;
            sys_addr_hold <= sel_addr;
          end else begin
            if (ts_now) begin
              pend      <= 1'b1;
              req_addr  <= cpu_addr;
              req_rd    <= cpu_rd;
              req_burst <= cpu_burst;
            end
            if (bedge && st == GAP) st <= IDLE;
          end
        end
        ADDR: begin
          if (bedge) begin
            st         <= DATA;
            sys_ts_n   <= 1'b1;
            sys_ad_out <= cpu_wdata;
            sys_ad_oe  <= ~cur_rd;
          end
        end
        DATA: begin
          if (ack) begin
            beat <= beat + 1'b1;
            if (last) begin
              st        <= GAP;
              sys_bb_n  <= 1'b1;
              sys_ad_oe <= 1'b0;
            end
          end else if (!bedge && !cur_rd) begin
            sys_ad_out <= cpu_wdata;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  p_sys_on_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({sys_ts_n, sys_bb_n, sys_ad_oe}) |-> phase);

  p_ts_one_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_ts_n) |=> !sys_ts_n ##1 sys_ts_n);

  p_ts_drives_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_ts_n |-> sys_ad_oe);

  p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_bb_n && sys_ts_n) |-> $stable(sys_addr_hold));

  p_release_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_bb_n) |=> sys_bb_n);

  p_ts_under_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_ts_n |-> !sys_bb_n);

  p_ack_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ta_n |=> cpu_ta_n);

  p_ack_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ta_n |-> phase);
endmodule

// File: tb/sim_x2_bus_translator.sv
module sim_x2_bus_translator;
  typedef struct packed {
    logic [31:0]      addr;
    logic             rd;
    logic             burst;
    int               waits;
    logic [3:0][31:0] wd;
    logic [3:0][31:0] rdv;
  } txn_t;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        cpu_ts_n = 1'b1, cpu_rd = 1'b0, cpu_burst = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_ta_n, bus_clk, sys_ts_n, sys_bb_n, sys_ad_oe;
  logic [31:0] cpu_rdata, sys_ad_out, sys_addr_hold;
  logic [31:0] sys_ad_in;
  logic        sys_ta_n;

  x2_bus_translator #(.W(32), .BURST_LEN(4)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_ts_n(cpu_ts_n), .cpu_rd(cpu_rd),
    .cpu_burst(cpu_burst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ta_n(cpu_ta_n), .cpu_rdata(cpu_rdata), .bus_clk(bus_clk),
    .sys_ts_n(sys_ts_n), .sys_bb_n(sys_bb_n), .sys_ad_out(sys_ad_out),
    .sys_ad_oe(sys_ad_oe), .sys_ad_in(sys_ad_in), .sys_ta_n(sys_ta_n),
    .sys_addr_hold(sys_addr_hold));

  int   total = 0, bad = 0;
  bit   stray = 1'b0;
  txn_t sysq[$];
  logic [32:0] cpuq[$];

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // system-side slave: acts once per bus period, in its late half
  initial begin : slave
    txn_t cur;
    bit   active = 1'b0, prev_bb = 1'b1;
    int   beat_s = 0, wcnt = 0;
    cur = '0;
    sys_ta_n = 1'b1;
    sys_ad_in = '0;
    forever begin
      @(negedge clk);
      if (!rst_n || bus_clk) continue;
      sys_ta_n = 1'b1;
      if (!sys_ts_n) begin
        if (stray) sys_ta_n = 1'b0;
        if (sysq.size() == 0) chk(1'b0, "R3", "unexpected start", 32'd1, 32'd0);
        else begin
          cur = sysq.pop_front();
          chk(sys_ad_oe && sys_ad_out == cur.addr, "R3", "address on shared bus", sys_ad_out, cur.addr);
          chk(sys_addr_hold == cur.addr, "R4", "held address at start", sys_addr_hold, cur.addr);
          chk(prev_bb, "R5", "busy released a period before start", 32'(prev_bb), 32'd1);
          active = 1'b1; beat_s = 0; wcnt = cur.waits;
        end
      end else if (active) begin
        chk(sys_addr_hold == cur.addr, "R4", "held address in data phase", sys_addr_hold, cur.addr);
        chk(!sys_bb_n, "R5", "busy held in data phase", 32'(sys_bb_n), 32'd0);
        if (!cur.rd)
          chk(sys_ad_oe && sys_ad_out == cur.wd[beat_s], "R8", "write data on bus", sys_ad_out, cur.wd[beat_s]);
        if (wcnt > 0) wcnt--;
        else begin
          sys_ta_n = 1'b0;
          sys_ad_in = cur.rdv[beat_s];
          beat_s++;
          wcnt = cur.waits;
          if (beat_s == (cur.burst ? 4 : 1)) active = 1'b0;
        end
      end else if (stray) begin
        sys_ta_n = 1'b0;
      end
      prev_bb = sys_bb_n;
    end
  end

  // monitor: pops expected acknowledges
  initial begin : monitor
    logic [32:0] e;
    bit prev_ta = 1'b1;
    forever begin
      @(negedge clk);
      if (!rst_n) continue;
      if (!cpu_ta_n) begin
        chk(prev_ta, "R6", "ack lasts one fast cycle", 32'(prev_ta), 32'd1);
        chk(bus_clk, "R6", "ack starts at bus edge", 32'(bus_clk), 32'd1);
        if (cpuq.size() == 0) chk(1'b0, "R9", "unexpected ack", 32'd1, 32'd0);
        else begin
          e = cpuq.pop_front();
          if (e[32]) chk(cpu_rdata == e[31:0], "R6", "read data", cpu_rdata, e[31:0]);
        end
      end
      prev_ta = cpu_ta_n;
    end
  end

  task automatic xfer(logic [31:0] a, bit rd, bit burst, int waits, logic [31:0] base);
    txn_t t;
    int n = burst ? 4 : 1;
    int acks = 0, lat;
    bit seen = 1'b0, ph;
    t = '0;
    t.addr = a; t.rd = rd; t.burst = burst; t.waits = waits;
    for (int i = 0; i < 4; i++) begin
      t.wd[i]  = base + 32'h0101_0101 * i;
      t.rdv[i] = ~base - 32'(i);
    end
    sysq.push_back(t);
    for (int i = 0; i < n; i++) cpuq.push_back({rd, t.rdv[i]});
    ph = bus_clk;
    cpu_ts_n = 1'b0; cpu_addr = a; cpu_rd = rd; cpu_burst = burst; cpu_wdata = t.wd[0];
    @(negedge clk);
    cpu_ts_n = 1'b1; cpu_addr = ~a; cpu_rd = ~rd; cpu_burst = ~burst;
    lat = 1;
    forever begin
      if (!seen && !sys_ts_n) begin
        seen = 1'b1;
        chk(lat == (ph ? 2 : 1), "R3", "start latency", 32'(lat), ph ? 32'd2 : 32'd1);
      end
      if (!cpu_ta_n) begin
        acks++;
        if (acks < n) begin
          cpu_wdata = t.wd[acks];
          chk(!sys_bb_n, "R7", "burst continues", 32'(sys_bb_n), 32'd0);
        end else chk(sys_bb_n, "R7", "transfer ends after last beat", 32'(sys_bb_n), 32'd1);
      end
      if (acks == n) break;
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL R10 watchdog expired act=%0d exp=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    bit pb;
    repeat (5) @(negedge clk);
    chk(sys_ts_n && sys_bb_n && cpu_ta_n && !sys_ad_oe, "R1", "reset outputs",
        {28'd0, sys_ts_n, sys_bb_n, cpu_ta_n, sys_ad_oe}, 32'he);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sys_ts_n && sys_bb_n && cpu_ta_n && !sys_ad_oe, "R1", "outputs after reset",
        {28'd0, sys_ts_n, sys_bb_n, cpu_ta_n, sys_ad_oe}, 32'he);
    pb = bus_clk;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(bus_clk != pb, "R2", "bus clock toggles", 32'(bus_clk), 32'(!pb));
      pb = bus_clk;
    end
    xfer(32'h1000_0040, 1'b1, 1'b0, 0, 32'hA5A5_0000);
    @(negedge clk);
    xfer(32'h2000_0080, 1'b0, 1'b0, 1, 32'h1234_5678);
    xfer(32'h3000_0100, 1'b1, 1'b1, 0, 32'hCAFE_0000);
    xfer(32'h4000_0200, 1'b0, 1'b1, 0, 32'h0BAD_0000);
    repeat (3) @(negedge clk);
    xfer(32'h5000_0300, 1'b1, 1'b1, 2, 32'h7777_0000);
    xfer(32'h6000_0400, 1'b0, 1'b1, 1, 32'h3C3C_0000);
    repeat (2) @(negedge clk);
    stray = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(cpu_ta_n && sys_ts_n, "R9", "stray acknowledge while idle",
          {30'd0, cpu_ta_n, sys_ts_n}, 32'd3);
    end
    xfer(32'h7000_0500, 1'b1, 1'b1, 1, 32'h5A5A_0000);
    stray = 1'b0;
    @(negedge clk);
    xfer(32'h8000_0600, 1'b0, 1'b0, 3, 32'hFFFF_0000);
    repeat (10) @(negedge clk);
    chk(cpuq.size() == 0, "R10", "all acknowledges delivered", 32'(cpuq.size()), 32'd0);
    chk(sysq.size() == 0, "R3", "all transfers started", 32'(sysq.size()), 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule